// File: doc/BRIEF.md
# Protected Flit Stream Validator

This block sits at the receiving end of a packet link and judges each arriving packet. Every flit arrives as a 22-bit single-error-correcting, double-error-detecting codeword that protects a 16-bit payload. The block repairs any single flipped bit, flags codewords with two flipped bits, and hands the decoded payload downstream one cycle later.

Above the flit level it enforces packet framing. A packet opens with a header flit that names the sender and states how many flits the packet holds, header included. The end of a packet is marked by a last-flit strobe that travels with the final flit. A flit that arrives while no packet is open and is not a clean header is destroyed. When a packet closes, its flit count is compared with the header's figure. A mismatch drops the packet and raises a one-cycle retransmission request carrying the sender's address. An uncorrectable flit anywhere inside the packet also causes the packet to be dropped.

Top module: `flit_validator`

## Requirements
- R1: A codeword with no flipped bit yields its payload with the fixed and uncorrectable flags low. Codeword bit i (i = 1..21) is Hamming position i, with check bits at positions 1, 2, 4, 8 and 16. Payload bit k sits at the k-th position, in ascending order, that is not a power of two (3, 5, 6, 7, 9, ...). Bit 0 makes the parity of all 22 bits even.
- R2: A codeword with exactly one flipped bit, at any of the 22 positions, yields the original payload with the fixed flag high.
- R3: A codeword with exactly two flipped bits raises the uncorrectable flag and leaves the fixed flag low.
- R4: Payload bit 15 set marks a header. In a header, bits [7:4] hold the sender address and bits [3:0] hold the packet length in flits, counting the header itself.
- R5: While no packet is open, a flit that is not a header, or that is uncorrectable, is destroyed. The block pulses the stray-drop output, gives no flit output and gives no packet verdict.
- R6: When the last-flit strobe arrives, the packet is accepted (one-cycle accept pulse) if its flit count equals the header length and none of its flits was uncorrectable.
- R7: When the flit count at the last-flit strobe differs from the header length, including a header length of 0, the block pulses drop and the retransmission request together. The retransmission address equals the header's sender field.
- R8: A packet whose count matches but which contained an uncorrectable flit is dropped without a retransmission request.
- R9: Each accepted flit appears at the outputs one cycle after it is presented. A packet verdict appears in the cycle after its last flit.
- R10: Reset clears all outputs and closes any open packet, so the next flit must be a header. After any verdict, the next flit must also be a header.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A codeword is presented this cycle |
| in_last | input | 1 | The presented flit closes its packet |
| in_code | input | 22 | Protected flit codeword |
| o_flit_valid | output | 1 | A flit of an open packet is presented |
| o_flit_data | output | 16 | Decoded payload |
| o_flit_head | output | 1 | The decoded payload is marked as a header |
| o_flit_fixed | output | 1 | A single-bit error was corrected |
| o_flit_bad | output | 1 | The codeword was uncorrectable |
| o_stray_drop | output | 1 | A flit arriving outside a packet was destroyed |
| o_pkt_ok | output | 1 | Packet accepted |
| o_pkt_drop | output | 1 | Packet dropped |
| o_retx_req | output | 1 | Retransmission request pulse |
| o_retx_src | output | 4 | Sender address for the request |

## Verification
Bit correction and the packet verdict can occur in the same cycle. The bench provokes this with single-flit packets whose only flit is both header and last and carries one flipped bit. In that cycle the corrected header must be presented with the fixed flag set, and the accept or the retransmission decision must be taken from the corrected length and sender fields. A second collision appears when a closing packet is both short and contains an uncorrectable flit. The bench expects drop and retransmission in that one cycle. A scoreboard computes the expected outputs from its own encoder and framing model.

// File: rtl/fv_pkg.sv
package fv_pkg;

    // number of Hamming check bits needed for a payload width
    function automatic int par_bits(input int dw);
        int r;
        r = 1;
        while ((1 << r) < dw + r + 1) r++;
        return r;
    endfunction

    // total codeword width including the overall parity bit
    function automatic int code_w(input int dw);
        return dw + par_bits(dw) + 1;
    endfunction

    // Hamming position of payload bit k (k-th non power of two)
    function automatic int data_pos(input int k);
        int n;
        int pos;
        n   = -1;
        pos = 0;
        for (int i = 1; i < 256; i++) begin
            if ((i & (i - 1)) != 0) begin
                n++;
                if (n == k && pos == 0) pos = i;
            end
        end
        return pos;
    endfunction

endpackage

// File: rtl/secded_dec.sv
module secded_dec #(
    parameter int DATA_W = 16
) (
    input  logic [fv_pkg::code_w(DATA_W)-1:0] code_i,
    output logic [DATA_W-1:0]                 data_o,
    output logic                              fixed_o,
    output logic                              bad_o
);
    localparam int PAR_W  = fv_pkg::par_bits(DATA_W);
    localparam int CODE_W = fv_pkg::code_w(DATA_W);

    logic [PAR_W-1:0]  syn_d;
    logic              par_d;
    logic [CODE_W-1:0] rep_d;

    always_comb begin
        syn_d = '0;
        for (int i = 1; i < CODE_W; i++) begin
            if (code_i[i]) syn_d = syn_d ^ PAR_W'(i);
        end
        par_d   = ^code_i;
        rep_d   = code_i;
        fixed_o = 1'b0;
        bad_o   = 1'b0;
        if (par_d) begin
            if (int'(syn_d) < CODE_W) begin
                rep_d[syn_d] = ~code_i[syn_d];
                fixed_o      = 1'b1;
            end else begin
                bad_o = 1'b1;
            end
        end else if (syn_d != '0) begin
            bad_o = 1'b1;
        end
    end

    for (genvar k = 0; k < DATA_W; k++) begin : g_extract
        assign data_o[k] = rep_d[fv_pkg::data_pos(k)];
    end

endmodule

// File: rtl/flit_framer.sv
module flit_framer #(
    parameter int DATA_W = 16,
    parameter int SRC_W  = 4,
    parameter int LEN_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_last,
    input  logic [DATA_W-1:0] dec_data,
    input  logic              dec_fixed,
    input  logic              dec_bad,
    output logic              flit_valid,
    output logic [DATA_W-1:0] flit_data,
    output logic              flit_head,
    output logic              flit_fixed,
    output logic              flit_bad,
    output logic              stray_drop,
    output logic              pkt_ok,
    output logic              pkt_drop,
    output logic              retx_req,
    output logic [SRC_W-1:0]  retx_src
);
    localparam int HEAD_BIT = DATA_W - 1;
    localparam int SRC_LSB  = LEN_W;
    localparam int CNT_W    = LEN_W + 1;
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic              open;
        logic [CNT_W-1:0]  cnt;
        logic [LEN_W-1:0]  len;
        logic [SRC_W-1:0]  src;
        logic              tainted;
        logic              fv;
        logic [DATA_W-1:0] fd;
        logic              fh;
        logic              ffix;
        logic              fbad;
        logic              stray;
        logic              ok;
        logic              drop;
        logic              retx;
        logic [SRC_W-1:0]  rsrc;
    } fr_state_t;

    fr_state_t st_d, st_q;

    logic              close_d;
    logic [CNT_W-1:0]  cnt_n_d;
    logic              taint_n_d;
    logic              mismatch_d;

    always_comb begin
        st_d       = st_q;
        st_d.fv    = 1'b0;
        st_d.ffix  = 1'b0;
        st_d.fbad  = 1'b0;
        st_d.stray = 1'b0;
        st_d.ok    = 1'b0;
        st_d.drop  = 1'b0;
        st_d.retx  = 1'b0;
        close_d    = 1'b0;
        cnt_n_d    = st_q.cnt;
        taint_n_d  = st_q.tainted;
        mismatch_d = 1'b0;

        if (in_valid) begin
            if (!st_q.open) begin
                if (dec_bad || !dec_data[HEAD_BIT]) begin
                    st_d.stray = 1'b1;
                end else begin
                    st_d.fv      = 1'b1;
                    st_d.fd      = dec_data;
                    st_d.fh      = 1'b1;
                    st_d.ffix    = dec_fixed;
                    st_d.len     = dec_data[LEN_W-1:0];
                    st_d.src     = dec_data[SRC_LSB +: SRC_W];
                    cnt_n_d      = CNT_W'(1);
                    taint_n_d    = 1'b0;
                    st_d.open    = !in_last;
                    close_d      = in_last;
                end
            end else begin
                st_d.fv   = 1'b1;
                st_d.fd   = dec_data;
                st_d.fh   = dec_data[HEAD_BIT];
                st_d.ffix = dec_fixed;
                st_d.fbad = dec_bad;
                cnt_n_d   = (st_q.cnt == CNT_MAX) ? st_q.cnt : st_q.cnt + CNT_W'(1);
                taint_n_d = st_q.tainted | dec_bad;
                st_d.open = !in_last;
                close_d   = in_last;
            end
            st_d.cnt     = cnt_n_d;
            st_d.tainted = taint_n_d;
        end

        if (close_d) begin
            mismatch_d = (cnt_n_d != {1'b0, st_d.len});
            st_d.ok    = !mismatch_d && !taint_n_d;
            st_d.drop  = mismatch_d || taint_n_d;
            st_d.retx  = mismatch_d;
            st_d.rsrc  = st_d.src;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flit_valid = st_q.fv;
    assign flit_data  = st_q.fd;
    assign flit_head  = st_q.fh;
    assign flit_fixed = st_q.ffix;
    assign flit_bad   = st_q.fbad;
    assign stray_drop = st_q.stray;
    assign pkt_ok     = st_q.ok;
    assign pkt_drop   = st_q.drop;
    assign retx_req   = st_q.retx;
    assign retx_src   = st_q.rsrc;

    // R5: stray destruction, accept and drop never share a cycle
    p_one_event_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({stray_drop, pkt_ok, pkt_drop}));

    // R5: a destroyed flit is never presented downstream
    p_stray_hidden_r5: assert property (@(posedge clk) disable iff (!rst_n)
        stray_drop |-> !flit_valid);

    // R7: a retransmission request always comes with a drop
    p_retx_with_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        retx_req |-> pkt_drop);

    // R9: a verdict follows a presented last flit by one cycle
    p_verdict_after_last_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_ok || pkt_drop) |-> $past(in_valid && in_last));

    // R10: once a packet closes, the next accepted flit is a header
    p_head_after_close_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_ok || pkt_drop) |=> (flit_valid |-> flit_head));

endmodule

// File: rtl/flit_validator.sv
module flit_validator #(
    parameter int DATA_W = 16,
    parameter int SRC_W  = 4,
    parameter int LEN_W  = 4
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              in_valid,
    input  logic                              in_last,
    input  logic [fv_pkg::code_w(DATA_W)-1:0] in_code,
    output logic                              o_flit_valid,
    output logic [DATA_W-1:0]                 o_flit_data,
    output logic                              o_flit_head,
    output logic                              o_flit_fixed,
    output logic                              o_flit_bad,
    output logic                              o_stray_drop,
    output logic                              o_pkt_ok,
    output logic                              o_pkt_drop,
    output logic                              o_retx_req,
    output logic [SRC_W-1:0]                  o_retx_src
);
    logic [DATA_W-1:0] dec_data;
    logic              dec_fixed;
    logic              dec_bad;

    secded_dec #(.DATA_W(DATA_W)) u_dec (
        .code_i  (in_code),
        .data_o  (dec_data),
        .fixed_o (dec_fixed),
        .bad_o   (dec_bad)
    );

    flit_framer #(.DATA_W(DATA_W), .SRC_W(SRC_W), .LEN_W(LEN_W)) u_frame (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_last    (in_last),
        .dec_data   (dec_data),
        .dec_fixed  (dec_fixed),
        .dec_bad    (dec_bad),
        .flit_valid (o_flit_valid),
        .flit_data  (o_flit_data),
        .flit_head  (o_flit_head),
        .flit_fixed (o_flit_fixed),
        .flit_bad   (o_flit_bad),
        .stray_drop (o_stray_drop),
        .pkt_ok     (o_pkt_ok),
        .pkt_drop   (o_pkt_drop),
        .retx_req   (o_retx_req),
        .retx_src   (o_retx_src)
    );

    // R3: the decoder never claims both a repair and a failure
    p_fix_or_bad_r3: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> !(dec_fixed && dec_bad));

    // R9: a presented flit is always one cycle behind an input flit
    p_flit_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
        o_flit_valid |-> $past(in_valid));

endmodule

// File: tb/flit_validator_bench.sv
module flit_validator_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_last = 1'b0;
    logic [21:0] in_code = '0;
    logic        o_flit_valid, o_flit_head, o_flit_fixed, o_flit_bad;
    logic [15:0] o_flit_data;
    logic        o_stray_drop, o_pkt_ok, o_pkt_drop, o_retx_req;
    logic [3:0]  o_retx_src;

    always #4 clk = ~clk;

    flit_validator u_flit_validator (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_last(in_last),
        .in_code(in_code), .o_flit_valid(o_flit_valid), .o_flit_data(o_flit_data),
        .o_flit_head(o_flit_head), .o_flit_fixed(o_flit_fixed), .o_flit_bad(o_flit_bad),
        .o_stray_drop(o_stray_drop), .o_pkt_ok(o_pkt_ok), .o_pkt_drop(o_pkt_drop),
        .o_retx_req(o_retx_req), .o_retx_src(o_retx_src)
    );

    typedef struct {
        bit fv; bit [15:0] d; bit hd; bit fx; bit bd;
        bit st; bit ok; bit dr; bit rt; bit [3:0] sr;
    } exp_t;

    exp_t exp_q[$];
    int   n_chk = 0;
    int   n_bad = 0;

    // bench model of framing
    bit       m_open = 0;
    int       m_cnt = 0;
    int       m_len = 0;
    bit [3:0] m_src = 0;
    bit       m_taint = 0;

    function automatic bit [21:0] enc(input bit [15:0] d);
        bit [21:0] cw;
        int k;
        bit p;
        cw = '0;
        k = 0;
        for (int i = 3; i < 22; i++) begin
            if ((i & (i - 1)) != 0) begin
                cw[i] = d[k];
                k++;
            end
        end
        for (int b = 0; b < 5; b++) begin
            p = 0;
            for (int i = 1; i < 22; i++)
                if (((i >> b) & 1) == 1 && i != (1 << b)) p ^= cw[i];
            cw[1 << b] = p;
        end
        cw[0] = ^cw[21:1];
        return cw;
    endfunction

    function automatic exp_t idle_rec();
        exp_t e;
        e = '{default: 0};
        return e;
    endfunction

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 0;
            in_last  = 0;
            exp_q.push_back(idle_rec());
        end
    endtask

    // present one flit; e1/e2 are bit positions to flip, -1 for none
    task automatic flit(input bit [15:0] d, input bit last, input int e1, input int e2);
        exp_t e;
        bit [21:0] cw;
        int nf;
        cw = enc(d);
        nf = 0;
        if (e1 >= 0) begin cw[e1] ^= 1'b1; nf++; end
        if (e2 >= 0) begin cw[e2] ^= 1'b1; nf++; end
        e = idle_rec();
        if (!m_open) begin
            if (nf == 2 || !d[15]) begin
                e.st = 1;                       // R5
            end else begin
                e.fv = 1; e.d = d; e.hd = 1; e.fx = (nf == 1);
                m_cnt = 1; m_len = int'(d[3:0]); m_src = d[7:4]; m_taint = 0;
                m_open = !last;
                if (last) begin
                    e.ok = (m_cnt == m_len); e.dr = !e.ok; e.rt = !e.ok; e.sr = m_src;
                end
            end
        end else begin
            e.fv = 1; e.d = d; e.hd = d[15]; e.fx = (nf == 1); e.bd = (nf == 2);
            if (m_cnt < 31) m_cnt++;
            m_taint |= (nf == 2);
            m_open = !last;
            if (last) begin
                e.rt = (m_cnt != m_len);
                e.ok = !e.rt && !m_taint;
                e.dr = !e.ok;
                e.sr = m_src;
            end
        end
        @(negedge clk);
        in_valid = 1;
        in_last  = last;
        in_code  = cw;
        exp_q.push_back(e);
    endtask

    function automatic bit [15:0] hdr(input bit [3:0] src, input bit [3:0] len);
        return {1'b1, 7'h2A, src, len};
    endfunction

    task automatic packet(input bit [3:0] src, input int len_field, input int nflits,
                          input int err_idx, input int e1, input int e2);
        for (int i = 0; i < nflits; i++) begin
            bit [15:0] d;
            d = (i == 0) ? hdr(src, 4'(len_field)) : {1'b0, 15'(16'h1357 * (i + 3) + src)};
            if (i == err_idx) flit(d, i == nflits - 1, e1, e2);
            else              flit(d, i == nflits - 1, -1, -1);
        end
    endtask

    // monitor / scoreboard
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (exp_q.size() > 0) begin
                exp_t e;
                bit miss;
                e = exp_q.pop_front();
                miss = 0;
                n_chk++;
                if (o_flit_valid !== e.fv) begin
                    miss = 1; $display("FAIL R9 flit_valid act=%0b exp=%0b", o_flit_valid, e.fv);
                end
                if (e.fv && !e.bd && o_flit_data !== e.d) begin
                    miss = 1; $display("FAIL R2 data act=%h exp=%h", o_flit_data, e.d);
                end
                if (e.fv && !e.bd && o_flit_head !== e.hd) begin
                    miss = 1; $display("FAIL R4 head act=%0b exp=%0b", o_flit_head, e.hd);
                end
                if (e.fv && o_flit_fixed !== e.fx) begin
                    miss = 1; $display("FAIL R1 fixed act=%0b exp=%0b", o_flit_fixed, e.fx);
                end
                if (e.fv && o_flit_bad !== e.bd) begin
                    miss = 1; $display("FAIL R3 bad act=%0b exp=%0b", o_flit_bad, e.bd);
                end
                if (o_stray_drop !== e.st) begin
                    miss = 1; $display("FAIL R5 stray act=%0b exp=%0b", o_stray_drop, e.st);
                end
                if (o_pkt_ok !== e.ok) begin
                    miss = 1; $display("FAIL R6 ok act=%0b exp=%0b", o_pkt_ok, e.ok);
                end
                if (o_pkt_drop !== e.dr) begin
                    miss = 1; $display("FAIL R8 drop act=%0b exp=%0b", o_pkt_drop, e.dr);
                end
                if (o_retx_req !== e.rt) begin
                    miss = 1; $display("FAIL R7 retx act=%0b exp=%0b", o_retx_req, e.rt);
                end
                if (e.rt && o_retx_src !== e.sr) begin
                    miss = 1; $display("FAIL R7 retx_src act=%h exp=%h", o_retx_src, e.sr);
                end
                if (miss) n_bad++;
            end
        end
    end

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired act=running exp=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        n_chk++;    // R10 reset state
        if ({o_flit_valid, o_stray_drop, o_pkt_ok, o_pkt_drop, o_retx_req} !== 5'b0) begin
            n_bad++;
            $display("FAIL R10 reset outputs act=%b exp=00000",
                     {o_flit_valid, o_stray_drop, o_pkt_ok, o_pkt_drop, o_retx_req});
        end
        @(negedge clk);
        rst_n = 1;
        idle(2);

        // R1 R6: clean three-flit packet
        packet(4'h5, 3, 3, -1, -1, -1);
        idle(1);
        // R2: every single-bit position, in header and in tail
        for (int p = 0; p < 22; p++) begin
            packet(4'(p), 2, 2, 0, p, -1);
            packet(4'(p), 2, 2, 1, 21 - p, -1);
        end
        // R3 R8: double error in middle flit, count correct
        packet(4'h9, 3, 3, 1, 4, 13);
        // R5: stray data flits and uncorrectable first flit
        flit({1'b0, 15'h1234}, 1'b0, -1, -1);
        flit({1'b0, 15'h4321}, 1'b1, -1, -1);
        flit(hdr(4'h3, 4'h2), 1'b0, 2, 7);
        idle(1);
        // R7: short and long packets
        packet(4'hA, 4, 2, -1, -1, -1);
        packet(4'hB, 2, 3, -1, -1, -1);
        // R7: header length zero
        packet(4'hC, 0, 1, -1, -1, -1);
        // single-flit packets with a corrected bit closing in the same cycle
        packet(4'hD, 1, 1, 0, 9, -1);
        packet(4'hE, 3, 1, 0, 0, -1);
        // R7 R8: short and tainted
        packet(4'h6, 5, 3, 2, 3, 17);
        // R10: reset while a packet is open, then a data flit is stray
        flit(hdr(4'h7, 4'h4), 1'b0, -1, -1);
        @(negedge clk);
        rst_n = 0; in_valid = 0;
        exp_q.push_back(idle_rec());
        @(negedge clk);
        exp_q.push_back(idle_rec());
        m_open = 0;
        @(negedge clk);
        rst_n = 1;
        exp_q.push_back(idle_rec());
        flit({1'b0, 15'h0F0F}, 1'b1, -1, -1);
        packet(4'h1, 2, 2, -1, -1, -1);
        idle(4);
        @(posedge clk);
        #3;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule